// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a direct-mapped cache placed between a processor request port and a slower next-level memory. A processor request may read a word, read a byte, or write a word. The block splits the address into a tag, a set index and a byte offset. Each set holds one line with a valid flag, a tag and a parameterized number of 32-bit words. A read that hits a valid line with a matching tag completes in the same cycle.

On a miss, the block runs a line fill. The fill asks the next level for one word per cycle. The next level answers each request in the same cycle with one of three results: data, an error, or a stall that carries a wait count. After a stall, the fill waits out that count and then asks again for the same word. It does not start the line over. The set takes the new tag, the new data and the valid flag only when the last word arrives.

Writes use write-allocate. A write that misses first fills its line, and the write then proceeds as a hit. A write that hits updates the word in the cache and also sends the same word to the next level. Any error from the next level is returned to the requester. The processor holds its request steady until the block reports completion.

Top module: `dmc_top`

## Requirements
- R1: The address fields are split as follows. The byte offset is the low log2(LINE_WORDS)+2 bits, and bits [3:2] select the word within the line. The set index is the next log2(SETS) bits, and the tag is the remaining upper bits. Two addresses with the same index and different tags evict each other.
- R2: A byte read (req_byte=1) returns byte lane addr[1:0] of the addressed word, shifted down to rsp_rdata[7:0], with rsp_rdata[31:8] = 0.
- R3: A fill reads the next level at line base + 4*k for k = 0..LINE_WORDS-1, in increasing order. Each word is accepted exactly once per fill.
- R4: A stall answer with count N makes the fill idle for N cycles. It then retries the same word, N+1 cycles after the stall, and continues from there without refetching earlier words.
- R5: An error answer during a fill completes the request with rsp_err=1 in that cycle. The line is not made valid, so a repeat of the request fetches again.
- R6: The tag, the data and the valid flag of a set change together, at the end of the fill's last word. A clean read miss completes LINE_WORDS+1 cycles after it is presented. A later hit completes in the same cycle and makes no next-level read.
- R7: A write miss first fills the whole line (LINE_WORDS reads) and then performs the write. The write completes LINE_WORDS+1 cycles after it is presented.
- R8: A write hit updates the cached word and drives the same word to the next level in the same cycle. An error answer to that write gives rsp_err=1.
- R9: rsp_busy is high while a fill is in progress. A completion that occurs while busy is always an error completion.
- R10: Reset clears every valid flag and all fill state. After reset, rsp_done, rsp_busy and mem_rd are low, and the first read misses.
- R11: A write never finds its line missing directly after its own allocation fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present, held until rsp_done |
| req_write | input | 1 | 1 = word write, 0 = read |
| req_byte | input | 1 | Byte read when 1 (reads only) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Request completes this cycle |
| rsp_err | output | 1 | Completion carries a next-level error |
| rsp_busy | output | 1 | Line fill in progress |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_rd | output | 1 | Next-level word read |
| mem_we | output | 1 | Next-level word write |
| mem_addr | output | ADDR_W | Next-level word address |
| mem_wdata | output | 32 | Next-level write data |
| mem_ack | input | 1 | Next level accepted (read data valid / write done) |
| mem_stall | input | 1 | Next level asks for a wait |
| mem_stall_cycles | input | STALL_W | Wait length for a stall |
| mem_err | input | 1 | Next level rejects the address |
| mem_rdata | input | 32 | Next-level read data |

## Verification
The bench first runs a clean miss on every set. It then reads every word and every byte lane of each filled line. The data, the miss and hit latencies, and the next-level read counts show whether the address split, the lane shifting and the fill ordering are correct. Two tags that share one index show that lines are evicted and do not alias. Stalls are injected on a middle word and on the first word, with different wait counts. A restarted fill gives a higher read count than a resumed one, and a miscounted wait shows in the retry gap. Reads from a rejected region, write misses, write hits, and writes that the next level rejects cover error completion, allocation and write-through.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int WOFF_W = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WOFF_W-1:0] woff_o,
    output logic [1:0]        lane_o
);
    localparam int OFF_W = WOFF_W + 2;

    assign tag_o  = addr_i[ADDR_W-1 -: TAG_W];
    assign idx_o  = addr_i[OFF_W +: IDX_W];
    assign woff_o = addr_i[2 +: WOFF_W];
    assign lane_o = addr_i[1:0];
endmodule

// File: rtl/dmc_lane_sel.sv
module dmc_lane_sel (
    input  logic [31:0] word_i,
    input  logic [1:0]  lane_i,
    input  logic        byte_i,
    output logic [31:0] data_o
);
    always_comb begin
        if (byte_i) begin
            data_o = (word_i >> {lane_i, 3'b000}) & 32'h0000_00FF;
        end else begin
            data_o = word_i;
        end
    end
endmodule

// File: rtl/dmc_top.sv
module dmc_top
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int STALL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_byte,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic                rsp_busy,
    output logic [31:0]         rsp_rdata,
    output logic                mem_rd,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic                mem_stall,
    input  logic [STALL_W-1:0]  mem_stall_cycles,
    input  logic                mem_err,
    input  logic [31:0]         mem_rdata
);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = WOFF_W + 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

    typedef logic [LINE_WORDS-1:0][31:0] line_t;

    typedef struct packed {
        dmc_state_e                   st;
        logic [SETS-1:0]              valid;
        logic [SETS-1:0][TAG_W-1:0]   tags;
        logic [SETS-1:0][LINE_WORDS-1:0][31:0] data;
        logic [WOFF_W-1:0]            nxt;
        logic [STALL_W-1:0]           cnt;
        line_t                        fbuf;
        logic                         after_fill;
    } state_t;

    state_t d, q;

    logic [TAG_W-1:0]  tag;
    logic [IDX_W-1:0]  idx;
    logic [WOFF_W-1:0] woff;
    logic [1:0]        lane;
    logic              hit;
    logic [31:0]       line_word;
    logic [31:0]       lane_data;
    logic              alloc_fault;
    line_t             fill_line;

    dmc_addr_split #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W),
        .WOFF_W (WOFF_W)
    ) split_i (
        .addr_i (req_addr),
        .tag_o  (tag),
        .idx_o  (idx),
        .woff_o (woff),
        .lane_o (lane)
    );

    assign hit       = q.valid[idx] && (q.tags[idx] == tag);
    assign line_word = q.data[idx][woff];

    dmc_lane_sel lane_i (
        .word_i (line_word),
        .lane_i (lane),
        .byte_i (req_byte),
        .data_o (lane_data)
    );

    always_comb begin
        d           = q;
        rsp_done    = 1'b0;
        rsp_err     = 1'b0;
        rsp_busy    = 1'b0;
        rsp_rdata   = '0;
        mem_rd      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        alloc_fault = 1'b0;
        fill_line   = q.fbuf;

        unique case (q.st)
            ST_IDLE: begin
                d.after_fill = 1'b0;
                if (req_valid) begin
                    if (hit) begin
                        if (!req_write) begin
                            rsp_done  = 1'b1;
                            rsp_rdata = lane_data;
                        end else begin
                            mem_we                = 1'b1;
                            mem_addr              = req_addr;
                            mem_wdata             = req_wdata;
                            d.data[idx][woff]     = req_wdata;
                            if (mem_ack || mem_err) begin
                                rsp_done = 1'b1;
                                rsp_err  = mem_err;
                            end
                        end
                    end else begin
                        alloc_fault = q.after_fill && req_write;
                        d.st  = ST_FILL;
                        d.nxt = '0;
                        d.cnt = '0;
                    end
                end
            end

            ST_FILL: begin
                rsp_busy = 1'b1;
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - STALL_W'(1);
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = {tag, idx, q.nxt, 2'b00};
                    if (mem_err) begin
                        rsp_done = 1'b1;
                        rsp_err  = 1'b1;
                        d.st     = ST_IDLE;
                    end else if (mem_stall) begin
                        d.cnt = mem_stall_cycles;
                    end else if (mem_ack) begin
                        fill_line[q.nxt] = mem_rdata;
                        d.fbuf           = fill_line;
                        if (q.nxt == LAST_WORD) begin
                            d.valid[idx] = 1'b1;
                            d.tags[idx]  = tag;
                            d.data[idx]  = fill_line;
                            d.st         = ST_IDLE;
                            d.after_fill = 1'b1;
                        end else begin
                            d.nxt = q.nxt + WOFF_W'(1);
                        end
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st         <= ST_IDLE;
            q.valid      <= '0;
            q.tags       <= '0;
            q.data       <= '0;
            q.nxt        <= '0;
            q.cnt        <= '0;
            q.fbuf       <= '0;
            q.after_fill <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // Word acceptance moves the fill pointer forward by one.
    assert_fill_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_rd && mem_ack && !mem_stall && !mem_err && q.nxt != LAST_WORD)
        |=> (q.nxt == $past(q.nxt) + WOFF_W'(1)));

    // A stall loads the countdown with the next level's count.
    assert_stall_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_rd && mem_stall && !mem_err)
        |=> (q.cnt == $past(mem_stall_cycles) && q.nxt == $past(q.nxt)));

    // No next-level read while the countdown runs.
    assert_stall_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && q.cnt != '0) |-> !mem_rd);

    // An error during a fill never validates a line.
    assert_err_nocommit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_rd && mem_err) |=> (q.valid == $past(q.valid)));

    // Last word commits the line.
    assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_rd && mem_ack && !mem_stall && !mem_err && q.nxt == LAST_WORD)
        |=> (q.valid[$past(idx)] && q.tags[$past(idx)] == $past(tag)));

    // Next-level writes happen only for processor writes that hit.
    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_valid && req_write && !rsp_busy && !mem_rd));

    // Completion while busy must be an error completion.
    assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_busy && rsp_done) |-> rsp_err);

    // Allocation always precedes the write.
    assert_alloc_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_fault);
endmodule

// File: tb/dmc_top_tb_top.sv
`timescale 1ns/1ps
module dmc_top_tb_top;
    localparam int AW = 12;
    localparam int SETS = 4;
    localparam int LW = 4;
    localparam int SW = 4;
    localparam logic [AW-1:0] RERR_BASE = 12'hE00;
    localparam logic [AW-1:0] WERR_BASE = 12'hD00;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_write, req_byte;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_done, rsp_err, rsp_busy;
    logic [31:0]   rsp_rdata;
    logic          mem_rd, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack, mem_stall, mem_err;
    logic [SW-1:0] mem_stall_cycles;
    logic [31:0]   mem_rdata;

    dmc_top #(.ADDR_W(AW), .SETS(SETS), .LINE_WORDS(LW), .STALL_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_busy(rsp_busy), .rsp_rdata(rsp_rdata),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_stall(mem_stall), .mem_stall_cycles(mem_stall_cycles),
        .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int i);
        return 32'h9E37_79B9 * (i + 1) ^ 32'h5A00_00A5;
    endfunction

    // Next-level model
    logic [31:0]   mem_m [0:1023];
    int            stall_id = 0;
    int            stall_used = 0;
    logic [AW-1:0] stall_addr = '0;
    logic [SW-1:0] stall_n = '0;
    int            cyc, rd_cnt, wr_cnt, stall_cyc, retry_cyc;

    always_comb begin
        mem_ack = 1'b0; mem_stall = 1'b0; mem_err = 1'b0;
        mem_rdata = '0; mem_stall_cycles = '0;
        if (mem_rd) begin
            if (mem_addr >= RERR_BASE) mem_err = 1'b1;
            else if (stall_id != stall_used && mem_addr == stall_addr) begin
                mem_stall = 1'b1; mem_stall_cycles = stall_n;
            end else begin
                mem_ack = 1'b1; mem_rdata = mem_m[mem_addr[11:2]];
            end
        end
        if (mem_we) begin
            if (mem_addr >= WERR_BASE) mem_err = 1'b1;
            else mem_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem_m[i] <= init_word(i);
            cyc <= 0; rd_cnt <= 0; wr_cnt <= 0; stall_cyc <= 0; retry_cyc <= 0;
        end else begin
            cyc <= cyc + 1;
            if (mem_rd && mem_ack) rd_cnt <= rd_cnt + 1;
            if (mem_rd && mem_stall) begin
                stall_used <= stall_id;
                stall_cyc  <= cyc;
            end
            if (mem_rd && mem_ack && mem_addr == stall_addr) retry_cyc <= cyc;
            if (mem_we && mem_ack) begin
                mem_m[mem_addr[11:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    int checks = 0;
    int fails = 0;
    logic [31:0] shadow [0:1023];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input bit w, input bit b, input logic [AW-1:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output bit er, output int lat, output bit saw_busy);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a; req_wdata = wd;
        lat = 0; saw_busy = 1'b0; rd = '0; er = 1'b0;
        while (1) begin
            #1;
            if (rsp_busy) saw_busy = 1'b1;
            if (rsp_done) begin rd = rsp_rdata; er = rsp_err; break; end
            if (lat > 200) begin lat = -1; break; end
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit er, bz;
        int lat, r0, w0;
        logic [AW-1:0] a, base;

        for (int i = 0; i < 1024; i++) shadow[i] = init_word(i);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!rsp_done && !rsp_busy && !mem_rd, "R10 reset outputs", {rsp_done, rsp_busy, mem_rd}, 0);
        rst_n = 1'b1;

        // Clean miss on every set, then sweep words and lanes (R1 R2 R3 R6 R9 R10)
        for (int s = 0; s < SETS; s++) begin
            base = {6'd1, 2'(s), 4'h0};
            r0 = rd_cnt;
            do_req(0, 0, base | 12'h4, 0, rd, er, lat, bz);
            chk(lat == LW + 1, "R10 first read misses, R6 miss latency", lat, LW + 1);
            chk(rd == shadow[(base >> 2) + 1], "R3 filled word data", rd, shadow[(base >> 2) + 1]);
            chk(rd_cnt - r0 == LW, "R3 one read per word", rd_cnt - r0, LW);
            chk(bz, "R9 busy during fill", bz, 1);
            r0 = rd_cnt;
            for (int wi = 0; wi < LW; wi++) begin
                a = base | 12'(wi * 4);
                do_req(0, 0, a, 0, rd, er, lat, bz);
                chk(lat == 0 && rd == shadow[a >> 2], "R6 word hit", rd, shadow[a >> 2]);
                for (int ln = 0; ln < 4; ln++) begin
                    logic [31:0] ex;
                    ex = (shadow[a >> 2] >> (8 * ln)) & 32'hFF;
                    do_req(0, 1, a | 12'(ln), 0, rd, er, lat, bz);
                    chk(lat == 0 && rd == ex, "R2 byte lane", rd, ex);
                end
            end
            chk(rd_cnt == r0, "R6 hits make no next-level read", rd_cnt - r0, 0);
        end

        // Conflict on one index (R1)
        do_req(0, 0, {6'd2, 2'd1, 4'h8}, 0, rd, er, lat, bz);
        chk(lat == LW + 1, "R1 other tag misses", lat, LW + 1);
        chk(rd == shadow[{6'd2, 2'd1, 2'd2}], "R1 other tag data", rd, shadow[{6'd2, 2'd1, 2'd2}]);
        do_req(0, 0, {6'd1, 2'd1, 4'h8}, 0, rd, er, lat, bz);
        chk(lat == LW + 1, "R1 evicted tag misses again", lat, LW + 1);
        do_req(0, 0, {6'd1, 2'd2, 4'h8}, 0, rd, er, lat, bz);
        chk(lat == 0, "R1 other set untouched", lat, 0);

        // Stall in mid-line, count 3 (R4 R3)
        base = {6'd3, 2'd0, 4'h0};
        stall_addr = base | 12'h8; stall_n = 4'd3; stall_id++;
        r0 = rd_cnt;
        do_req(0, 0, base, 0, rd, er, lat, bz);
        chk(lat == LW + 1 + 4, "R4 stall adds N+1 cycles", lat, LW + 5);
        chk(rd_cnt - r0 == LW, "R4 fill resumes without refetch", rd_cnt - r0, LW);
        chk(retry_cyc - stall_cyc == 4, "R4 retry gap", retry_cyc - stall_cyc, 4);
        chk(rd == shadow[base >> 2], "R4 data after stall", rd, shadow[base >> 2]);

        // Stall on first word, count 0
        base = {6'd3, 2'd1, 4'h0};
        stall_addr = base; stall_n = 4'd0; stall_id++;
        r0 = rd_cnt;
        do_req(0, 0, base | 12'hC, 0, rd, er, lat, bz);
        chk(lat == LW + 2, "R4 zero-count stall", lat, LW + 2);
        chk(rd_cnt - r0 == LW && rd == shadow[(base >> 2) + 3], "R4 data after zero stall", rd, shadow[(base >> 2) + 3]);

        // Error on fill (R5)
        do_req(0, 0, 12'hE14, 0, rd, er, lat, bz);
        chk(er && lat == 1, "R5 error completes", {er, 8'(lat)}, {1'b1, 8'd1});
        do_req(0, 0, 12'hE14, 0, rd, er, lat, bz);
        chk(er && lat == 1, "R5 line stays invalid", {er, 8'(lat)}, {1'b1, 8'd1});

        // Write miss: allocate then write through (R7 R8 R11)
        a = {6'd4, 2'd3, 4'h4};
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(1, 0, a, 32'hCAFE_0001, rd, er, lat, bz);
        shadow[a >> 2] = 32'hCAFE_0001;
        chk(lat == LW + 1 && !er, "R7 write miss latency", lat, LW + 1);
        chk(rd_cnt - r0 == LW, "R7 allocation reads line", rd_cnt - r0, LW);
        chk(wr_cnt - w0 == 1 && mem_m[a >> 2] == 32'hCAFE_0001, "R8 write reaches next level", mem_m[a >> 2], 32'hCAFE_0001);
        do_req(0, 0, a, 0, rd, er, lat, bz);
        chk(lat == 0 && rd == 32'hCAFE_0001, "R8 cached word updated", rd, 32'hCAFE_0001);
        do_req(0, 0, a | 12'h8, 0, rd, er, lat, bz);
        chk(lat == 0 && rd == shadow[(a >> 2) + 2], "R7 rest of line filled", rd, shadow[(a >> 2) + 2]);

        // Write hit (R8)
        a = {6'd4, 2'd3, 4'hC};
        w0 = wr_cnt;
        do_req(1, 0, a, 32'h1234_5678, rd, er, lat, bz);
        chk(lat == 0 && !er && wr_cnt - w0 == 1, "R8 write hit", lat, 0);
        chk(mem_m[a >> 2] == 32'h1234_5678, "R8 write-through data", mem_m[a >> 2], 32'h1234_5678);
        do_req(0, 1, a | 12'h2, 0, rd, er, lat, bz);
        chk(rd == 32'h34, "R2 byte of written word", rd, 32'h34);

        // Next level rejects the write (R8)
        do_req(1, 0, 12'hD08, 32'hDEAD_BEEF, rd, er, lat, bz);
        chk(er && lat == LW + 1, "R8 write error returned", {er, 8'(lat)}, {1'b1, 8'(LW + 1)});

        summary();
        $finish;
    end
endmodule